// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a watchdog built from a free-running up-counter and a compare register of the same width. The counter advances by one on every clock on which the tick input is high. When the count equals the compare value on such a clock while the watchdog is armed, the block raises a system reset request. The request is a registered pulse of fixed length, so downstream reset logic sees it cleanly.

Software keeps the system alive by reading the counter, adding its chosen delay, and writing the sum to the compare register. The sum is taken modulo the counter range, so a deadline past the wrap point is valid. Timeout resolution is one tick, and the longest timeout is one full counter period. Arming is a one-way operation: once the enable bit is set, only a reset clears it.

A small register port gives access to the live count, the compare value and the enable bit. Reads are registered.

Top module: `wdog_match_top`

## Requirements
- R1: The counter is CNT_W bits wide (default 32). It resets to zero and increments by one on each clock edge where `cnt_tick` is high. It holds its value when `cnt_tick` is low, and it wraps from all ones to zero.
- R2: A synchronous active-high `rst` clears the counter, the compare register, the enable bit, `rst_req` and `rd_data`.
- R3: The register map by address is: 0 = live count, read-only, and writes to it are ignored; 1 = compare value, read/write; 2 = control, with the enable bit at bit 0 and zeros above it; 3 = reads as zero. `rd_data` is registered. After a clock edge it shows the register selected by `rd_addr` at that edge, with the value that register held just before the edge.
- R4: A write to the compare register loads it at the edge of the write. A comparison at that same edge still uses the old value, and every later edge uses the new value.
- R5: Writing a control word with bit 0 set sets the enable bit. Writing bit 0 as zero leaves the enable bit unchanged, and only `rst` clears it.
- R6: A timeout fires at a clock edge where `cnt_tick` is high, the enable bit is set and the count equals the compare value. `rst_req` is high after that edge. Take the case where the tick runs continuously and the compare value is written as count + D, with D from 1 up to one full counter period minus 1 and the sum modulo 2^CNT_W. Here the count is the value the count read-back would show at the write edge. Then `rst_req` rises D edges after the write edge, including when the sum wraps past zero.
- R7: No timeout fires while the enable bit is clear or while `cnt_tick` is low, even when the count equals the compare value.
- R8: `rst_req` stays high for exactly PULSE_CYC clock cycles (default 4) after a timeout. A new timeout during the pulse restarts the full length.
- R9: Writing a compare value equal to the current count gives a timeout after a full counter period of 2^CNT_W ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Counter advance qualifier |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| rst_req | output | 1 | System reset request pulse |

## Verification
The hardest situations to reach are the counter wrap and the full-period timeout, since a 32-bit counter needs billions of ticks to get there. The bench builds the block with a 10-bit counter, so both the wrap-crossing deadline and the compare-equals-count case complete within about a thousand cycles. The tick input is also held low while the count sits exactly on the compare value, which shows that the comparison is qualified by the tick. A compare value is also written one tick ahead while a pulse is already running, which forces a restart of the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WA_COUNT = 2'd0,
    WA_MATCH = 2'd1,
    WA_CTRL  = 2'd2,
    WA_SPARE = 2'd3
  } wa_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)))); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/wdog_compare.sv
module wdog_compare #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             armed,
  input  logic             ld_match,
  input  logic [CNT_W-1:0] ld_value,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] match_q,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst)           match_q <= '0;
    else if (ld_match) match_q <= ld_value;
  end

  assign hit = tick && armed && (cnt_q == match_q);

  AST_MATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_match |=> (match_q == $past(ld_value))); // R4
  AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    !ld_match |=> $stable(match_q)); // R4
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic req_q
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      req_q  <= 1'b0;
    end else if (hit) begin
      left_q <= PW'(PULSE_CYC);
      req_q  <= 1'b1;
    end else begin
      if (left_q != '0) left_q <= left_q - PW'(1);
      req_q <= (left_q > PW'(1));
    end
  end

  AST_HIT_RAISES: assert property (@(posedge clk) disable iff (rst)
    hit |=> req_q); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (!hit && left_q == '0) |=> !req_q); // R8
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic             wr_bit0,
  input  logic [1:0]       rd_addr,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] match_q,
  output logic             en_q,
  output logic [CNT_W-1:0] rd_q
);
  logic set_en;
  logic [CNT_W-1:0] rd_nxt;

  assign set_en = wr_en && (wr_addr == WA_CTRL) && wr_bit0;

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (set_en) en_q <= 1'b1;
  end

  always_comb begin
    case (wa_e'(rd_addr))
      WA_COUNT: rd_nxt = cnt_q;
      WA_MATCH: rd_nxt = match_q;
      WA_CTRL:  rd_nxt = {{(CNT_W-1){1'b0}}, en_q};
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q); // R5
  AST_EN_SET_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(set_en)); // R5
endmodule

// File: rtl/wdog_match_top.sv
module wdog_match_top
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] match_q;
  logic             en_q;
  logic             hit;
  logic             ld_match;

  assign ld_match = wr_en && (wr_addr == WA_MATCH);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (cnt_tick),
    .cnt_q (cnt_q)
  );

  wdog_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .tick     (cnt_tick),
    .armed    (en_q),
    .ld_match (ld_match),
    .ld_value (wr_data),
    .cnt_q    (cnt_q),
    .match_q  (match_q),
    .hit      (hit)
  );

  wdog_pulse #(.PULSE_CYC(PULSE_CYC)) u_pls (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .req_q (rst_req)
  );

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit0 (wr_data[0]),
    .rd_addr (rd_addr),
    .cnt_q   (cnt_q),
    .match_q (match_q),
    .en_q    (en_q),
    .rd_q    (rd_data)
  );

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> en_q); // R7
  AST_REQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(cnt_tick)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rst_req && rd_data == '0)); // R2
endmodule

// File: tb/tb_wdog_match_top.sv
module tb_wdog_match_top;
  localparam int TW = 10;
  localparam int PC = 4;
  localparam int NV = 6;
  // {rearm, delay}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 16'd1}, {1'b0, 16'd2}, {1'b1, 16'd3},
    {1'b0, 16'd7}, {1'b1, 16'd40}, {1'b0, 16'd100}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_tick = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [TW-1:0] rd_data;
  logic          rst_req;

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] m_cnt = '0;

  always #2 clk = ~clk;

  wdog_match_top #(.CNT_W(TW), .PULSE_CYC(PC)) dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rst_req(rst_req)
  );

  // Counter model from R1/R2
  always @(posedge clk) begin
    if (rst) m_cnt <= '0;
    else if (cnt_tick) m_cnt <= m_cnt + TW'(1);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [TW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [TW-1:0] v);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    while (rst_req !== 1'b1 && n < 3000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (rst_req === 1'b1 && w < 100) begin
      w++; @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [TW-1:0] v, v2, exp;
    int n, w, low;

    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 rst_req in reset", 32'(rst_req), 0);
    chk("R2 rd_data in reset", 32'(rd_data), 0);
    rst = 1'b0;
    exp = m_cnt; do_read(2'd0, v); chk("R1 count after reset", 32'(v), 32'(exp));
    do_read(2'd1, v); chk("R2 match zero", 32'(v), 0);
    do_read(2'd2, v); chk("R2 enable clear", 32'(v), 0);

    // R7: disabled, match passes without reset
    do_write(2'd1, m_cnt + TW'(5));
    low = 1;
    repeat (20) begin @(negedge clk); if (rst_req !== 1'b0) low = 0; end
    chk("R7 disabled no timeout", 32'(low), 1);

    // R3: count address read-only, spare reads zero, match readback
    do_write(2'd0, TW'(341));
    exp = m_cnt; do_read(2'd0, v); chk("R3 count write ignored", 32'(v), 32'(exp));
    do_read(2'd3, v); chk("R3 spare reads zero", 32'(v), 0);
    do_write(2'd1, TW'(777));
    do_read(2'd1, v); chk("R3 match readback", 32'(v), 777);

    // R5: enable W1S, sticky
    do_write(2'd2, TW'(1));
    do_read(2'd2, v); chk("R5 enable set", 32'(v), 1);
    do_write(2'd2, TW'(0));
    do_read(2'd2, v); chk("R5 zero write ignored", 32'(v), 1);

    // R6/R8 vector table
    for (int i = 0; i < NV; i++) begin
      int d;
      d = int'(VEC[i][15:0]);
      do_write(2'd1, m_cnt + TW'(d));
      if (VEC[i][16]) begin
        low = 1;
        repeat (d / 2) begin @(negedge clk); if (rst_req !== 1'b0) low = 0; end
        chk("R4 no early fire before rearm", 32'(low), 1);
        do_write(2'd1, m_cnt + TW'(d));
      end
      wait_rise(n);
      chk($sformatf("R6 delay %0d", d), 32'(n), 32'(d));
      pulse_width(w);
      chk("R8 pulse width", 32'(w), PC);
    end

    // R8: restart during pulse
    do_write(2'd1, m_cnt + TW'(6));
    wait_rise(n);
    chk("R6 delay 6", 32'(n), 6);
    do_write(2'd1, m_cnt + TW'(1));
    pulse_width(w);
    chk("R8 restart extends pulse", 32'(w), PC + 1);

    // R1: wrap of the counter
    while (m_cnt != TW'(1023)) @(negedge clk);
    do_read(2'd0, v); chk("R1 count at top", 32'(v), 1023);
    do_read(2'd0, v); chk("R1 count wraps to zero", 32'(v), 0);

    // R6: deadline past wrap
    while (m_cnt != TW'(1018)) @(negedge clk);
    do_write(2'd1, m_cnt + TW'(10));
    wait_rise(n);
    chk("R6 wrap-crossing deadline", 32'(n), 10);
    pulse_width(w);

    // R9: full period
    do_write(2'd1, m_cnt);
    wait_rise(n);
    chk("R9 full period", 32'(n), 1024);
    pulse_width(w);

    // R7/R1: tick low holds count and blocks the compare
    @(negedge clk); cnt_tick = 1'b0;
    do_write(2'd1, m_cnt);
    do_read(2'd0, v); do_read(2'd0, v2);
    chk("R1 count holds without tick", 32'(v2), 32'(v));
    low = 1;
    repeat (8) begin @(negedge clk); if (rst_req !== 1'b0) low = 0; end
    chk("R7 no fire without tick", 32'(low), 1);
    cnt_tick = 1'b1;
    @(negedge clk);
    chk("R6 fire on next tick", 32'(rst_req), 1);
    pulse_width(w);

    // R2: reset clears enable and compare
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 rst_req cleared", 32'(rst_req), 0);
    rst = 1'b0;
    do_read(2'd2, v); chk("R2 enable cleared by reset", 32'(v), 0);
    do_read(2'd1, v); chk("R2 match cleared by reset", 32'(v), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule